// File: doc/BRIEF.md
# DMA Channel Trigger Collector

This block gathers start requests for a bank of DMA channels and hands them on to a small set of priority queues. Every channel has one pending bit. Three sources can set it: a rising edge on the channel's own hardware event line, a chain pulse sent when another transfer completes, and a software write that sets the bit directly. Each channel also has an enable bit and a queue-select field. A pending channel is passed on by one push to the queue that its field names. The push carries the channel number.

Software reaches the block through a single write port. A 4-bit address selects a write-one action: set, clear, enable-set, enable-clear or missed-clear, each on the low or the high 32 channels. One more address loads a channel's queue selection. The pending, enable and missed vectors are driven out as ports, so the surrounding logic can read them.

Top module: `evq_event_ctrl`

## Requirements
- R1: After reset the pending, enable and missed vectors are all zero, every channel selects queue 0, and no push is made.
- R2: A 0-to-1 change on hw_evt[i] sets pending bit i, whether or not channel i is enabled. Holding the line high creates no further trigger.
- R3: Writing a 1 to bit i at address 0 (channels 0..31) or address 1 (channels 32..63) triggers a channel that is then forwarded even when its enable bit is clear.
- R4: A one-cycle pulse on chain_evt[i] sets pending bit i. A channel triggered by its hardware line or by a chain pulse is forwarded only when its enable bit is set.
- R5: Addresses 4/5 set enable bits and addresses 6/7 clear them, one bit per written 1. Zero bits change nothing. Clearing an enable keeps a pending bit that is already set.
- R6: Writing a 1 at address 2/3 clears that channel's pending bit and its software-trigger mark. If a new trigger arrives on the same channel in the same cycle, the channel stays pending.
- R7: A forwarded channel drives exactly the q_push bit of its selected queue for one cycle, with q_chan equal to the channel number, and its pending bit is clear in the next cycle unless a new trigger arrived. A write at address 10 loads the queue for channel wr_data[5:0] from wr_data[17:16].
- R8: When several channels are eligible, the lowest-numbered one is pushed. At most one push is made per cycle.
- R9: No push is made to a queue whose q_full bit is set. A channel aimed at a full queue stays pending, and an eligible channel aimed at another queue may go first.
- R10: A trigger on a channel that is already pending, and is not being forwarded in that cycle, sets its missed bit. Writing a 1 at address 8/9 clears the missed bit, and zero bits change nothing.
- R11: At every address pair, the even address acts on channels 0..31 (data bit i is channel i) and the odd address acts on channels 32..63 (data bit i is channel 32+i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_evt | input | 64 | Hardware event line for each channel, edge-detected |
| chain_evt | input | 64 | Completion chain pulse for each channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| q_full | input | 4 | Full flag of each queue |
| q_push | output | 4 | One-hot push request to a queue |
| q_chan | output | 6 | Channel number carried with the push |
| evt_pend | output | 64 | Pending bits |
| evt_enable | output | 64 | Enable bits |
| evt_missed | output | 64 | Missed-trigger bits |

## Verification
The assertions assume that the hw_evt lines are low while reset is applied, that chain_evt carries single-cycle pulses, and that q_full stays stable through each cycle, so that a push offered to a queue is also accepted by it. The stimulus drives every input at the falling edge, keeps each hardware line at a fixed level across several cycles, sends chain pulses that last one cycle, and issues at most one register write per cycle, always to one of the eleven defined addresses.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int unsigned NCH_DEF = 64;
  localparam int unsigned NQ_DEF  = 4;

  typedef enum logic [3:0] {
    RA_SET_LO  = 4'd0,
    RA_SET_HI  = 4'd1,
    RA_CLR_LO  = 4'd2,
    RA_CLR_HI  = 4'd3,
    RA_ENS_LO  = 4'd4,
    RA_ENS_HI  = 4'd5,
    RA_ENC_LO  = 4'd6,
    RA_ENC_HI  = 4'd7,
    RA_MCLR_LO = 4'd8,
    RA_MCLR_HI = 4'd9,
    RA_PRIO    = 4'd10
  } evq_reg_e;
endpackage

// File: rtl/evq_edge_det.sv
module evq_edge_det #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/evq_pick.sv
module evq_pick #(
  parameter int unsigned NCH = 64,
  parameter int unsigned NQ  = 4,
  parameter int unsigned CW  = $clog2(NCH),
  parameter int unsigned QW  = $clog2(NQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    elig,
  input  logic [NQ-1:0]     full,
  input  logic [NCH*QW-1:0] prio_flat,
  output logic              hit,
  output logic [CW-1:0]     chan,
  output logic [NQ-1:0]     push
);
  logic [NCH-1:0] ready;

  for (genvar g = 0; g < NCH; g++) begin : g_ready
    assign ready[g] = elig[g] & ~full[prio_flat[g*QW +: QW]];
  end

  always_comb begin
    hit  = 1'b0;
    chan = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (ready[i]) begin
        hit  = 1'b1;
        chan = CW'(i);
      end
    end
  end

  assign push = hit ? (NQ'(1) << prio_flat[int'(chan)*QW +: QW]) : '0;

  // R8: one push per cycle
  p_one_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(push));
  // R9: never push into a full queue
  p_no_full_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push & full) == '0);
  // R7: the picked channel was offered by the eligibility mask
  p_pick_eligible_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> elig[chan]);
endmodule

// File: rtl/evq_event_ctrl.sv
module evq_event_ctrl
  import evq_pkg::*;
#(
  parameter int unsigned NCH = NCH_DEF,
  parameter int unsigned NQ  = NQ_DEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         hw_evt,
  input  logic [NCH-1:0]         chain_evt,
  input  logic                   wr_en,
  input  logic [3:0]             wr_addr,
  input  logic [NCH/2-1:0]       wr_data,
  input  logic [NQ-1:0]          q_full,
  output logic [NQ-1:0]          q_push,
  output logic [$clog2(NCH)-1:0] q_chan,
  output logic [NCH-1:0]         evt_pend,
  output logic [NCH-1:0]         evt_enable,
  output logic [NCH-1:0]         evt_missed
);
  localparam int unsigned HALF     = NCH / 2;
  localparam int unsigned CW       = $clog2(NCH);
  localparam int unsigned QW       = $clog2(NQ);
  localparam int unsigned PRIO_LSB = 16;

  // Write-one mask for a low/high register pair
  function automatic logic [NCH-1:0] wmask(input logic we, input logic [3:0] a,
                                           input logic [3:0] lo_code,
                                           input logic [HALF-1:0] d);
    logic [NCH-1:0] m;
    m = '0;
    if (we && a == lo_code)              m[HALF-1:0]   = d;
    else if (we && a == lo_code + 4'd1)  m[NCH-1:HALF] = d;
    return m;
  endfunction

  logic [NCH-1:0] evt_q, frc_q, en_q, miss_q;
  logic [QW-1:0]  prio_q [NCH];
  logic [NCH*QW-1:0] prio_flat;
  logic [NCH-1:0] hw_rise, new_trig, fwd_mask, elig, new_miss;
  logic [NCH-1:0] set_m, clr_m, ens_m, enc_m, mclr_m;
  logic           hit;
  logic [CW-1:0]  pick_chan;
  logic           prio_wr;

  evq_edge_det #(.W(NCH)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(hw_evt), .rise(hw_rise)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_prio
    assign prio_flat[g*QW +: QW] = prio_q[g];
  end

  assign set_m  = wmask(wr_en, wr_addr, RA_SET_LO,  wr_data);
  assign clr_m  = wmask(wr_en, wr_addr, RA_CLR_LO,  wr_data);
  assign ens_m  = wmask(wr_en, wr_addr, RA_ENS_LO,  wr_data);
  assign enc_m  = wmask(wr_en, wr_addr, RA_ENC_LO,  wr_data);
  assign mclr_m = wmask(wr_en, wr_addr, RA_MCLR_LO, wr_data);
  assign prio_wr = wr_en && (wr_addr == RA_PRIO);

  assign new_trig = hw_rise | chain_evt | set_m;
  assign elig     = evt_q & (en_q | frc_q);

  evq_pick #(.NCH(NCH), .NQ(NQ), .CW(CW), .QW(QW)) u_pick (
    .clk(clk), .rst_n(rst_n), .elig(elig), .full(q_full),
    .prio_flat(prio_flat), .hit(hit), .chan(pick_chan), .push(q_push)
  );

  assign fwd_mask = hit ? (NCH'(1) << pick_chan) : '0;
  assign new_miss = new_trig & evt_q & ~fwd_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q  <= '0;
      frc_q  <= '0;
      en_q   <= '0;
      miss_q <= '0;
      for (int i = 0; i < NCH; i++) prio_q[i] <= '0;
    end else begin
      evt_q  <= (evt_q & ~clr_m & ~fwd_mask) | new_trig;
      frc_q  <= (frc_q & ~clr_m & ~fwd_mask) | set_m;
      en_q   <= (en_q | ens_m) & ~enc_m;
      miss_q <= (miss_q & ~mclr_m) | new_miss;
      if (prio_wr) prio_q[wr_data[CW-1:0]] <= wr_data[PRIO_LSB +: QW];
    end
  end

  assign q_chan     = pick_chan;
  assign evt_pend   = evt_q;
  assign evt_enable = en_q;
  assign evt_missed = miss_q;

  // R2: every trigger is latched, enabled or not
  p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|new_trig) |=> ((evt_q & $past(new_trig)) == $past(new_trig)));
  // R7: a forwarded channel leaves the pending set
  p_fwd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !new_trig[pick_chan]) |=> !evt_q[$past(pick_chan)]);
  // R4: only enabled or software-marked channels are pushed
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (en_q[pick_chan] || frc_q[pick_chan]));
  // R10: a repeated trigger is recorded as missed
  p_missed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|new_miss) |=> ((miss_q & $past(new_miss)) == $past(new_miss)));
  // R5: an enable clear does not drop a pending bit
  p_keep_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q[0] && enc_m[0] && !clr_m[0] && !fwd_mask[0]) |=> evt_q[0]);
endmodule

// File: tb/sim_evq_event_ctrl.sv
module sim_evq_event_ctrl;
  localparam int NCH = 64;
  localparam int NQ  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] hw_evt = '0, chain_evt = '0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [NQ-1:0] q_full = '0;
  logic [NQ-1:0] q_push;
  logic [5:0] q_chan;
  logic [NCH-1:0] evt_pend, evt_enable, evt_missed;

  evq_event_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .chain_evt(chain_evt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .q_full(q_full),
    .q_push(q_push), .q_chan(q_chan), .evt_pend(evt_pend),
    .evt_enable(evt_enable), .evt_missed(evt_missed)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [63:0] m_evt = '0, m_frc = '0, m_en = '0, m_miss = '0, m_hwp = '0;
  int m_prio [NCH];

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // lowest channel that is pending, allowed and aimed at a non-full queue
  function automatic int expect_pick();
    for (int i = 0; i < NCH; i++)
      if (m_evt[i] && (m_en[i] || m_frc[i]) && !q_full[m_prio[i]]) return i;
    return -1;
  endfunction

  function automatic logic [63:0] pair_mask(int lo);
    if (!wr_en) return '0;
    if (wr_addr == 4'(lo))     return {32'b0, wr_data};
    if (wr_addr == 4'(lo + 1)) return {wr_data, 32'b0};
    return '0;
  endfunction

  // one clock: check push, advance model, check state
  task automatic cyc(string tag);
    int p;
    logic [63:0] s, c, es, ec, mc, nw, fw;
    #1;
    p = expect_pick();
    chk({tag, " push"}, 64'(q_push), p < 0 ? 64'd0 : 64'(4'b1 << m_prio[p]));
    if (p >= 0) chk({tag, " chan"}, 64'(q_chan), 64'(p));
    @(posedge clk);
    s = pair_mask(0); c = pair_mask(2); es = pair_mask(4);
    ec = pair_mask(6); mc = pair_mask(8);
    nw = (hw_evt & ~m_hwp) | chain_evt | s;
    fw = p < 0 ? 64'd0 : (64'd1 << p);
    for (int i = 0; i < NCH; i++) begin
      if (nw[i] && m_evt[i] && !fw[i]) m_miss[i] = 1'b1;
      else if (mc[i]) m_miss[i] = 1'b0;
      if (nw[i]) m_evt[i] = 1'b1;
      else if (c[i] || fw[i]) m_evt[i] = 1'b0;
      if (s[i]) m_frc[i] = 1'b1;
      else if (c[i] || fw[i]) m_frc[i] = 1'b0;
      if (ec[i]) m_en[i] = 1'b0;
      else if (es[i]) m_en[i] = 1'b1;
    end
    if (wr_en && wr_addr == 4'd10) m_prio[wr_data[5:0]] = int'(wr_data[17:16]);
    m_hwp = hw_evt;
    @(negedge clk);
    chk({tag, " pending"}, evt_pend, m_evt);
    chk({tag, " enable"}, evt_enable, m_en);
    chk({tag, " missed"}, evt_missed, m_miss);
    wr_en = 1'b0; chain_evt = '0;
  endtask

  task automatic wr(int a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NCH; i++) m_prio[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 pending", evt_pend, 0); chk("R1 enable", evt_enable, 0);
    chk("R1 missed", evt_missed, 0); chk("R1 push", 64'(q_push), 0);

    hw_evt[5] = 1'b1; cyc("R2");
    chk("R2 latched while disabled", 64'(evt_pend[5]), 1);
    chk("R2 no push while disabled", 64'(q_push), 0);
    cyc("R2");
    chk("R2 level gives no retrigger", 64'(evt_missed[5]), 0);

    wr(4, 32'h0); cyc("R5");
    chk("R5 zero write no effect", evt_enable, 0);
    wr(4, 32'h20); cyc("R5");
    chk("R5 enable set", 64'(evt_enable[5]), 1);
    chk("R7 push queue0", 64'(q_push), 64'h1);
    chk("R7 push chan", 64'(q_chan), 5);
    cyc("R7");
    chk("R7 pending cleared", 64'(evt_pend[5]), 0);

    hw_evt[5] = 1'b0; cyc("R5");
    hw_evt[5] = 1'b1; wr(6, 32'h20); cyc("R5");
    chk("R5 pending kept after enable clear", 64'(evt_pend[5]), 1);
    chk("R5 disabled no push", 64'(q_push), 0);
    wr(2, 32'h20); cyc("R6");
    chk("R6 cleared", 64'(evt_pend[5]), 0);

    hw_evt[5] = 1'b0; cyc("R10");
    hw_evt[5] = 1'b1; cyc("R10");
    hw_evt[5] = 1'b0; cyc("R10");
    hw_evt[5] = 1'b1; cyc("R10");
    chk("R10 missed set", 64'(evt_missed[5]), 1);
    wr(8, 32'h0); cyc("R10");
    chk("R10 zero write keeps missed", 64'(evt_missed[5]), 1);
    wr(8, 32'h20); cyc("R10");
    chk("R10 missed cleared", 64'(evt_missed[5]), 0);
    wr(2, 32'h20); cyc("R6");

    chain_evt[40] = 1'b1; cyc("R4");
    chk("R4 chain latched", 64'(evt_pend[40]), 1);
    chk("R4 chain gated", 64'(q_push), 0);
    wr(5, 32'h100); cyc("R11");
    chk("R11 high half enable", 64'(evt_enable[40]), 1);
    chk("R11 push chan 40", 64'(q_chan), 40);
    cyc("R11");

    wr(0, 32'h400); cyc("R3");
    chk("R3 manual bypasses enable", 64'(q_chan), 10);
    chk("R3 push", 64'(q_push), 64'h1);
    cyc("R3");

    wr(10, 32'h0002_0003); cyc("R7");
    q_full = 4'b0100;
    wr(0, 32'h208); cyc("R9");
    chk("R9 other queue served", 64'(q_chan), 9);
    chk("R9 push queue0", 64'(q_push), 64'h1);
    cyc("R9");
    chk("R9 held pending", 64'(evt_pend[3]), 1);
    chk("R9 no push to full", 64'(q_push), 0);
    q_full = 4'b0000; #1;
    chk("R7 queue select", 64'(q_push), 64'h4);
    cyc("R7");

    wr(0, 32'h88); cyc("R8");
    chk("R8 lowest first", 64'(q_chan), 3);
    cyc("R8");
    chk("R8 next channel", 64'(q_chan), 7);
    cyc("R8");

    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(3) == 0)
        hw_evt = hw_evt ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      if ($urandom_range(3) == 0)
        chain_evt = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      q_full = 4'($urandom) & 4'($urandom);
      if ($urandom_range(1) == 0) begin
        int a;
        a = $urandom_range(10);
        if (a == 10) wr(10, {14'b0, 2'($urandom), 10'b0, 6'($urandom)});
        else wr(a, $urandom & $urandom);
      end
      cyc("R8 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule